// File: doc/BRIEF.md
# Virtualized ECC Address Translator

This block turns the physical address of a data access into the address where that access's second-tier error-correction bytes live. A physical address splits into a frame number (upper bits) and an in-page offset (lower 12 bits for 4 KB pages). Software loads a small fully associative table. Each entry binds one data frame to one ECC page and carries a per-page protection mode. The hardware only reads the table on lookups.

On a hit, the ECC address is the entry's ECC page number followed by a scaled offset. The scaled offset is the data offset divided by the page's access granularity and multiplied by 8 bytes of ECC per granule. Both steps are plain shifts. The page's code-strength code goes out with the address, so the memory side can apply the right decoder. A miss gives a fault response instead of an address.

Requests use a valid/ready handshake. Each accepted request gives exactly one registered response one cycle later, and that response is held under back-pressure.

Top module: `vecc_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and every table entry is invalid, so the first lookup of any frame faults.
- R2: A table write (wr_en=1) updates entry wr_idx at the clock edge. A request accepted in the same cycle as the write is translated with the previous contents, and a request accepted one cycle later sees the new entry.
- R3: A request is accepted when req_valid and req_ready are both 1. Its response appears with rsp_valid=1 in the next cycle. On a hit, rsp_ea = {epn, ecc_offset}, with rsp_fault=0.
- R4: The granularity code is wr_mode[1:0], where 0 means 64 B, 1 means 32 B, 2 means 16 B and 3 means 8 B. The ECC offset is (offset / granularity) * 8, so the offset is shifted right by 6, 5, 4 or 3 bits and then left by 3 bits.
- R5: When no valid entry holds the request's frame number, the response has rsp_fault=1, rsp_ea=0 and rsp_strength=0.
- R6: An entry written with wr_valid=0 never matches, even if its frame number equals the request's frame number.
- R7: When several valid entries hold the same frame number, the entry with the lowest index supplies the ECC page and the mode.
- R8: On a hit, rsp_strength equals wr_mode[3:2] of the matching entry, with 0 meaning detect only, 1 meaning single chipkill correct and 2 meaning double chipkill correct.
- R9: req_ready = !rsp_valid || rsp_ready. While rsp_valid=1 and rsp_ready=0, the response fields hold and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_pa | input | PA_W (40) | Physical data address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Lookup miss |
| rsp_ea | output | EPN_W+PAGE_BITS (36) | ECC address |
| rsp_strength | output | 2 | Code strength of the page |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W (4) | Entry to write |
| wr_valid | input | 1 | Valid bit written |
| wr_pfn | input | PA_W-PAGE_BITS (28) | Frame number written |
| wr_epn | input | EPN_W (24) | ECC page number written |
| wr_mode | input | 4 | {strength[1:0], granularity[1:0]} |

## Verification
The hardest case to reach from the ports is a table write and a request to the same frame in the same clock cycle. Only that case separates "effect on the next cycle" from a write that is visible at once. The stimulus drives the write strobe and the request on the same falling edge, and then repeats the request one cycle later, expecting first the old and then the new ECC page. Duplicate frame numbers in two entries, a matching but invalid entry, and a stalled response with a waiting request are set up the same way through the write port and rsp_ready.

// File: rtl/vecc_pkg.sv
package vecc_pkg;
  localparam int unsigned MODE_W     = 4;
  localparam int unsigned GRAN_CODES = 4;
  localparam int unsigned MAX_GLOG   = 6;  // log2 of the coarsest granule (64 B)
  localparam int unsigned ECC_LOG    = 3;  // log2 of ECC bytes per granule (8 B)

  typedef enum logic [1:0] {
    GRAN_64 = 2'd0,
    GRAN_32 = 2'd1,
    GRAN_16 = 2'd2,
    GRAN_8  = 2'd3
  } gran_e;

  typedef enum logic [1:0] {
    STR_DETECT  = 2'd0,
    STR_CORRECT = 2'd1,
    STR_DOUBLE  = 2'd2,
    STR_RSVD    = 2'd3
  } strength_e;

  function automatic gran_e mode_gran(input logic [MODE_W-1:0] m);
    return gran_e'(m[1:0]);
  endfunction

  function automatic strength_e mode_strength(input logic [MODE_W-1:0] m);
    return strength_e'(m[3:2]);
  endfunction
endpackage

// File: rtl/vecc_table.sv
module vecc_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PFN_W   = 28,
  parameter int unsigned EPN_W   = 24,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [IDX_W-1:0]                       wr_idx,
  input  logic                                   wr_valid,
  input  logic [PFN_W-1:0]                       wr_pfn,
  input  logic [EPN_W-1:0]                       wr_epn,
  input  logic [vecc_pkg::MODE_W-1:0]            wr_mode,
  output logic [ENTRIES-1:0]                     tbl_valid,
  output logic [ENTRIES-1:0][PFN_W-1:0]          tbl_pfn,
  output logic [ENTRIES-1:0][EPN_W-1:0]          tbl_epn,
  output logic [ENTRIES-1:0][vecc_pkg::MODE_W-1:0] tbl_mode
);
  logic [ENTRIES-1:0] ent_en;

  always_comb begin
    ent_en = '0;
    if (wr_en) ent_en[wr_idx] = 1'b1;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tbl_valid[e] <= 1'b0;
      else if (ent_en[e]) tbl_valid[e] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (ent_en[e]) begin
        tbl_pfn[e]  <= wr_pfn;
        tbl_epn[e]  <= wr_epn;
        tbl_mode[e] <= wr_mode;
      end
    end
  end

  // R2: a write lands in its entry at the next edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tbl_valid[$past(wr_idx)] == $past(wr_valid)) &&
              (tbl_epn[$past(wr_idx)] == $past(wr_epn)));
endmodule

// File: rtl/vecc_match.sv
module vecc_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PFN_W   = 28,
  parameter int unsigned EPN_W   = 24,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [PFN_W-1:0]                         key_pfn,
  input  logic [ENTRIES-1:0]                       tbl_valid,
  input  logic [ENTRIES-1:0][PFN_W-1:0]            tbl_pfn,
  input  logic [ENTRIES-1:0][EPN_W-1:0]            tbl_epn,
  input  logic [ENTRIES-1:0][vecc_pkg::MODE_W-1:0] tbl_mode,
  output logic                                     hit,
  output logic [EPN_W-1:0]                         sel_epn,
  output logic [vecc_pkg::MODE_W-1:0]              sel_mode
);
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] grant;
  logic [ENTRIES-1:0] lower_hit;   // some lower index already hit
  logic [IDX_W-1:0]   sel_idx;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = tbl_valid[e] && (tbl_pfn[e] == key_pfn);
  end

  assign lower_hit[0] = 1'b0;
  for (genvar e = 1; e < ENTRIES; e++) begin : g_pri
    assign lower_hit[e] = lower_hit[e-1] | hit_vec[e-1];
  end
  assign grant = hit_vec & ~lower_hit;

  always_comb begin
    sel_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grant[e]) sel_idx = IDX_W'(e);
    end
  end

  assign hit      = |hit_vec;
  assign sel_epn  = tbl_epn[sel_idx];
  assign sel_mode = tbl_mode[sel_idx];

  // R7: at most one entry wins, and it is the lowest matching one
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((hit_vec & (grant - 1'b1)) == '0) && (grant != '0));
endmodule

// File: rtl/vecc_scale.sv
module vecc_scale #(
  parameter int unsigned PAGE_BITS = 12
) (
  input  vecc_pkg::gran_e        gran,
  input  logic [PAGE_BITS-1:0]   offset,
  output logic [PAGE_BITS-1:0]   ecc_off
);
  import vecc_pkg::*;

  logic [GRAN_CODES-1:0][PAGE_BITS-1:0] cand;

  for (genvar g = 0; g < GRAN_CODES; g++) begin : g_gran
    localparam int unsigned SHR = MAX_GLOG - g;
    assign cand[g] = (offset >> SHR) << ECC_LOG;
  end

  assign ecc_off = cand[gran];
endmodule

// File: rtl/vecc_xlate.sv
module vecc_xlate #(
  parameter int unsigned PA_W      = 40,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned EPN_W     = 24,
  parameter int unsigned ENTRIES   = 16,
  localparam int unsigned PFN_W    = PA_W - PAGE_BITS,
  localparam int unsigned EA_W     = EPN_W + PAGE_BITS,
  localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [PA_W-1:0]             req_pa,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_fault,
  output logic [EA_W-1:0]             rsp_ea,
  output logic [1:0]                  rsp_strength,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_valid,
  input  logic [PFN_W-1:0]            wr_pfn,
  input  logic [EPN_W-1:0]            wr_epn,
  input  logic [vecc_pkg::MODE_W-1:0] wr_mode
);
  import vecc_pkg::*;

  // asynchronous assertion, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  logic rst_i;
  assign rst_i = rst_s2;

  logic [ENTRIES-1:0]                 tbl_valid;
  logic [ENTRIES-1:0][PFN_W-1:0]      tbl_pfn;
  logic [ENTRIES-1:0][EPN_W-1:0]      tbl_epn;
  logic [ENTRIES-1:0][MODE_W-1:0]     tbl_mode;

  vecc_table #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .EPN_W(EPN_W)) u_table (
    .clk(clk), .rst_n(rst_i),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_pfn(wr_pfn), .wr_epn(wr_epn), .wr_mode(wr_mode),
    .tbl_valid(tbl_valid), .tbl_pfn(tbl_pfn), .tbl_epn(tbl_epn), .tbl_mode(tbl_mode)
  );

  logic               hit;
  logic [EPN_W-1:0]   sel_epn;
  logic [MODE_W-1:0]  sel_mode;

  vecc_match #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .EPN_W(EPN_W)) u_match (
    .clk(clk), .rst_n(rst_i),
    .key_pfn(req_pa[PA_W-1:PAGE_BITS]),
    .tbl_valid(tbl_valid), .tbl_pfn(tbl_pfn), .tbl_epn(tbl_epn), .tbl_mode(tbl_mode),
    .hit(hit), .sel_epn(sel_epn), .sel_mode(sel_mode)
  );

  logic [PAGE_BITS-1:0] ecc_off;

  vecc_scale #(.PAGE_BITS(PAGE_BITS)) u_scale (
    .gran(mode_gran(sel_mode)),
    .offset(req_pa[PAGE_BITS-1:0]),
    .ecc_off(ecc_off)
  );

  // response stage: next-state and registers
  logic            accept;
  logic            vld_q, vld_d;
  logic            flt_q, flt_d;
  logic [EA_W-1:0] ea_q, ea_d;
  logic [1:0]      str_q, str_d;

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    vld_d = vld_q;
    if (accept)         vld_d = 1'b1;
    else if (rsp_ready) vld_d = 1'b0;
    flt_d = !hit;
    ea_d  = hit ? {sel_epn, ecc_off} : '0;
    str_d = hit ? 2'(mode_strength(sel_mode)) : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      flt_q <= flt_d;
      ea_q  <= ea_d;
      str_q <= str_d;
    end
  end

  assign rsp_valid    = vld_q;
  assign rsp_fault    = flt_q;
  assign rsp_ea       = ea_q;
  assign rsp_strength = str_q;

  // R3: every accepted request yields a response next cycle
  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_i)
    accept |=> rsp_valid);
  // R9: a stalled response holds its fields
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_ea) &&
                                  $stable(rsp_fault) && $stable(rsp_strength));
  // R5: a fault carries no address
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && rsp_fault) |-> (rsp_ea == '0) && (rsp_strength == 2'b00));
  // R4: ECC addresses are 8-byte aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && !rsp_fault) |-> (rsp_ea[ECC_LOG-1:0] == '0));
endmodule

// File: tb/vecc_xlate_bench.sv
module vecc_xlate_bench;
  localparam int PA_W = 40, PAGE_BITS = 12, EPN_W = 24, ENTRIES = 16;
  localparam int PFN_W = PA_W - PAGE_BITS, EA_W = EPN_W + PAGE_BITS, IDX_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n, req_valid, req_ready, rsp_valid, rsp_ready, rsp_fault;
  logic [PA_W-1:0] req_pa;
  logic [EA_W-1:0] rsp_ea;
  logic [1:0] rsp_strength;
  logic wr_en, wr_valid;
  logic [IDX_W-1:0] wr_idx;
  logic [PFN_W-1:0] wr_pfn;
  logic [EPN_W-1:0] wr_epn;
  logic [3:0] wr_mode;

  vecc_xlate u_vecc_xlate (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [EA_W-1:0] exp_ea(input logic [EPN_W-1:0] epn,
                                             input logic [1:0] g,
                                             input logic [PAGE_BITS-1:0] off);
    logic [PAGE_BITS-1:0] granules;
    granules = off >> (6 - g);
    return {epn, PAGE_BITS'(granules * 8)};
  endfunction

  task automatic wr(input int idx, input bit v, input logic [PFN_W-1:0] pfn,
                    input logic [EPN_W-1:0] epn, input logic [3:0] mode);
    @(negedge clk);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_valid = v; wr_pfn = pfn; wr_epn = epn; wr_mode = mode;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  // issue one request, return the sampled response one cycle later
  task automatic xl(input logic [PFN_W-1:0] pfn, input logic [PAGE_BITS-1:0] off,
                    output logic f, output logic [EA_W-1:0] ea, output logic [1:0] s);
    @(negedge clk);
    req_valid = 1; req_pa = {pfn, off};
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    f = rsp_fault; ea = rsp_ea; s = rsp_strength;
  endtask

  task automatic t_reset;
    logic f; logic [EA_W-1:0] ea; logic [1:0] s;
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 0);
    chk("R1 req_ready after reset", 64'(req_ready), 1);
    xl(28'h0, 12'h000, f, ea, s);
    chk("R1 empty table faults", 64'(f), 1);
  endtask

  task automatic t_hit;
    logic f; logic [EA_W-1:0] ea; logic [1:0] s;
    wr(3, 1, 28'h0012345, 24'h000ABC, 4'b0000);
    xl(28'h0012345, 12'h7C8, f, ea, s);
    chk("R3 hit fault", 64'(f), 0);
    chk("R3 hit ea", 64'(ea), 64'(exp_ea(24'h000ABC, 2'd0, 12'h7C8)));
    chk("R3 rsp_valid", 64'(rsp_valid), 1);
  endtask

  task automatic t_gran;
    logic f; logic [EA_W-1:0] ea; logic [1:0] s;
    for (int g = 0; g < 4; g++) begin
      wr(4 + g, 1, 28'h0100 + 28'(g), 24'h000200 + 24'(g), {2'b00, 2'(g)});
      xl(28'h0100 + 28'(g), 12'hFFF, f, ea, s);
      chk($sformatf("R4 gran %0d max offset", g), 64'(ea),
          64'(exp_ea(24'h000200 + 24'(g), 2'(g), 12'hFFF)));
      xl(28'h0100 + 28'(g), 12'h5A4, f, ea, s);
      chk($sformatf("R4 gran %0d mid offset", g), 64'(ea),
          64'(exp_ea(24'h000200 + 24'(g), 2'(g), 12'h5A4)));
    end
  endtask

  task automatic t_miss;
    logic f; logic [EA_W-1:0] ea; logic [1:0] s;
    xl(28'h0FFFFFF, 12'h010, f, ea, s);
    chk("R5 miss fault", 64'(f), 1);
    chk("R5 miss ea", 64'(ea), 0);
    chk("R5 miss strength", 64'(s), 0);
  endtask

  task automatic t_invalid;
    logic f; logic [EA_W-1:0] ea; logic [1:0] s;
    wr(3, 0, 28'h0012345, 24'h000ABC, 4'b0000);
    xl(28'h0012345, 12'h008, f, ea, s);
    chk("R6 invalid entry faults", 64'(f), 1);
  endtask

  task automatic t_same_cycle;
    logic f; logic [EA_W-1:0] ea; logic [1:0] s;
    wr(9, 1, 28'h0777, 24'h000111, 4'b0011);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd9; wr_valid = 1; wr_pfn = 28'h0777; wr_epn = 24'h000222; wr_mode = 4'b0011;
    req_valid = 1; req_pa = {28'h0777, 12'h040};
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R2 same-cycle write uses old entry", 64'(rsp_ea),
        64'(exp_ea(24'h000111, 2'd3, 12'h040)));
    xl(28'h0777, 12'h040, f, ea, s);
    chk("R2 next-cycle request sees new entry", 64'(ea),
        64'(exp_ea(24'h000222, 2'd3, 12'h040)));
  endtask

  task automatic t_priority;
    logic f; logic [EA_W-1:0] ea; logic [1:0] s;
    wr(12, 1, 28'h0999, 24'h000C00, 4'b1001);
    wr(2,  1, 28'h0999, 24'h000B00, 4'b0110);
    xl(28'h0999, 12'h100, f, ea, s);
    chk("R7 lowest index epn", 64'(ea), 64'(exp_ea(24'h000B00, 2'd2, 12'h100)));
    chk("R8 strength of winner", 64'(s), 1);
    wr(2, 0, 28'h0999, 24'h000B00, 4'b0110);
    xl(28'h0999, 12'h100, f, ea, s);
    chk("R7 next entry after invalidate", 64'(ea), 64'(exp_ea(24'h000C00, 2'd1, 12'h100)));
    chk("R8 strength double", 64'(s), 2);
  endtask

  task automatic t_stall;
    wr(0, 1, 28'h0AAA, 24'h000A0A, 4'b0000);
    wr(1, 1, 28'h0BBB, 24'h000B0B, 4'b0000);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_pa = {28'h0AAA, 12'h080};
    @(posedge clk);
    @(negedge clk);
    req_pa = {28'h0BBB, 12'h080};
    chk("R9 req_ready low while stalled", 64'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 stalled valid held", 64'(rsp_valid), 1);
    chk("R9 stalled ea held", 64'(rsp_ea), 64'(exp_ea(24'h000A0A, 2'd0, 12'h080)));
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R9 queued request after release", 64'(rsp_ea), 64'(exp_ea(24'h000B0B, 2'd0, 12'h080)));
    @(posedge clk);
    @(negedge clk);
    chk("R9 response drained", 64'(rsp_valid), 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_pa = '0; rsp_ready = 1;
    wr_en = 0; wr_idx = '0; wr_valid = 0; wr_pfn = '0; wr_epn = '0; wr_mode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hit();
    t_gran();
    t_miss();
    t_invalid();
    t_same_cycle();
    t_priority();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule